// File: doc/BRIEF.md
# Flash Query Mode Controller

This block holds the command decoding and parameter readout path of a parallel NOR flash device that can be interrogated by host software. The host drives an address, a command byte and write/read strobes, plus a select that says whether the bus is addressed in bytes or in 16-bit words. The block tracks three modes: plain array reading, an autoselect mode entered through a single input (the unlock sequence lives elsewhere), and a query mode in which reads return a fixed table of device identification and supply/timing parameters in place of array data.

Query mode can be entered from either array reading or autoselect. The block records which of the two it came from, so the reset command returns it there. Byte-mode addresses are halved onto the word-mode table offsets, and only the low byte is returned in that mode. Read data is registered and appears on the cycle after the read strobe.

Top module: `nor_query_ctrl`

## Requirements
- R1: After synchronous reset, `mode` is 0 (array read) and `rd_data` is 0.
- R2: In array mode, a read returns on the next cycle the value `array_rdata` had in the strobe cycle; while `rd_en` is low, `rd_data` keeps its value.
- R3: `auto_enter` high in array mode with no write in the same cycle moves `mode` to 1 (autoselect); in autoselect or query mode it is ignored.
- R4: A write of 98h to address 055h in word mode, or to 0AAh in byte mode, moves `mode` to 2 (query) from mode 0 or 1; 98h to any other address, and any other data value except F0h, leave the mode unchanged.
- R5: A write of F0h to any address leaves query mode for the mode it was entered from, leaves autoselect for array read, and keeps array read; a repeated 98h inside query mode keeps the recorded origin.
- R6: In query mode with word addressing, word offsets return: 10h 0051h, 11h 0052h, 12h 0059h, 13h 0002h, 15h 0040h, 1Bh 0045h, 1Ch 0055h, 1Fh 0004h, 21h 000Ah, 23h 0005h, 25h 0004h; offsets 14h, 16h to 1Ah, 1Dh, 1Eh, 20h, 22h, 24h and 26h return 0000h.
- R7: In byte addressing, an even address A reads the entry of word offset A/2 in bits 7:0 with bits 15:8 zero; an odd byte address or one with bit 8 or above set returns zero.
- R8: In word addressing, an address with any bit from 7 upward set, or an offset below 10h or above 26h, returns zero in query mode.
- R9: Reads in autoselect mode return zero, and reads in query mode never return `array_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Host address (word or byte units) |
| bus_wdata | input | 8 | Command byte |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| byte_mode | input | 1 | 1 = byte addressing, 0 = word addressing |
| auto_enter | input | 1 | Request to enter autoselect (unlock already done) |
| array_rdata | input | DATA_W | Data from the memory array |
| rd_data | output | DATA_W | Registered read data |
| mode | output | 2 | Current mode: 0 array, 1 autoselect, 2 query |

## Verification
The assertions watch on every cycle that a valid query command lands the controller in query mode, that the reset command leaves autoselect and query for the right destination, that `auto_enter` cannot disturb query mode, that array reads pass through and idle cycles hold the output, and that out-of-table query reads give zero. The exact table contents in both address units, the rejection of commands sent to the wrong address, and the memory of the origin mode across a repeated query command are shown only by the bench's sequences.

// File: rtl/nqc_pkg.sv
package nqc_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_AUTO  = 2'd1,
    MODE_QUERY = 2'd2
  } nqc_mode_e;

  localparam logic [7:0] CMD_QUERY = 8'h98;
  localparam logic [7:0] CMD_RESET = 8'hF0;

  localparam int OFF_W = 7;
  localparam logic [OFF_W-1:0] TBL_FIRST = 7'h10;
  localparam logic [OFF_W-1:0] TBL_LAST  = 7'h26;

  localparam logic [7:0] WORD_CMD_ADDR = 8'h55;
  localparam logic [7:0] BYTE_CMD_ADDR = 8'hAA;
endpackage

// File: rtl/nqc_addr_map.sv
module nqc_addr_map
  import nqc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              byte_mode,
  output logic              cmd_hit,
  output logic [OFF_W-1:0]  tbl_off,
  output logic              tbl_valid
);
  logic hi_clear;
  logic in_range;

  always_comb begin
    if (byte_mode) begin
      cmd_hit  = (addr == ADDR_W'(BYTE_CMD_ADDR));
      hi_clear = (addr[ADDR_W-1:8] == '0) && !addr[0];
      tbl_off  = addr[7:1];
    end else begin
      cmd_hit  = (addr == ADDR_W'(WORD_CMD_ADDR));
      hi_clear = (addr[ADDR_W-1:7] == '0);
      tbl_off  = addr[6:0];
    end
    in_range  = (tbl_off >= TBL_FIRST) && (tbl_off <= TBL_LAST);
    tbl_valid = hi_clear && in_range;
  end
endmodule

// File: rtl/nqc_param_rom.sv
module nqc_param_rom
  import nqc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [OFF_W-1:0]  off,
  output logic [DATA_W-1:0] entry
);
  logic [7:0] code;

  always_comb begin
    case (off)
      7'h10: code = 8'h51;   // 'Q'
      7'h11: code = 8'h52;   // 'R'
      7'h12: code = 8'h59;   // 'Y'
      7'h13: code = 8'h02;   // primary command set id
      7'h15: code = 8'h40;   // extended table pointer
      7'h1B: code = 8'h45;   // supply min, volts.tenths
      7'h1C: code = 8'h55;   // supply max
      7'h1F: code = 8'h04;   // single write time exponent
      7'h21: code = 8'h0A;   // block erase time exponent
      7'h23: code = 8'h05;   // write max multiplier exponent
      7'h25: code = 8'h04;   // block erase max multiplier exponent
      default: code = 8'h00; // absent / unsupported fields
    endcase
    entry = DATA_W'(code);
  end
endmodule

// File: rtl/nqc_mode_fsm.sv
module nqc_mode_fsm
  import nqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       cmd_hit,
  input  logic       auto_enter,
  output nqc_mode_e  mode
);
  nqc_mode_e mode_q;
  logic      from_auto_q;

  logic is_query_cmd;
  logic is_reset_cmd;
  assign is_query_cmd = wr_en && (wdata == CMD_QUERY) && cmd_hit;
  assign is_reset_cmd = wr_en && (wdata == CMD_RESET);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_ARRAY;
      from_auto_q <= 1'b0;
    end else if (is_reset_cmd) begin
      if (mode_q == MODE_QUERY) mode_q <= from_auto_q ? MODE_AUTO : MODE_ARRAY;
      else                      mode_q <= MODE_ARRAY;
    end else if (is_query_cmd) begin
      if (mode_q != MODE_QUERY) begin
        mode_q      <= MODE_QUERY;
        from_auto_q <= (mode_q == MODE_AUTO);
      end
    end else if (!wr_en && auto_enter && mode_q == MODE_ARRAY) begin
      mode_q <= MODE_AUTO;
    end
  end

  assign mode = mode_q;

  // R4: a correctly addressed query command always lands in query mode
  a_r4_query_entry: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata == CMD_QUERY && cmd_hit) |=> (mode_q == MODE_QUERY));

  // R5: reset command leaves autoselect for array read
  a_r5_auto_exit: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_AUTO && wr_en && wdata == CMD_RESET) |=> (mode_q == MODE_ARRAY));

  // R5: reset command never leaves the block in query mode
  a_r5_query_leave: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_QUERY && wr_en && wdata == CMD_RESET) |=> (mode_q != MODE_QUERY));

  // R3: autoselect request cannot disturb query mode
  a_r3_auto_ignored: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_QUERY && !wr_en && auto_enter) |=> (mode_q == MODE_QUERY));
endmodule

// File: rtl/nor_query_ctrl.sv
module nor_query_ctrl
  import nqc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              byte_mode,
  input  logic              auto_enter,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        mode
);
  localparam int HALF_W = DATA_W / 2;

  logic             cmd_hit;
  logic [OFF_W-1:0] tbl_off;
  logic             tbl_valid;
  logic [DATA_W-1:0] rom_entry;
  logic [DATA_W-1:0] query_word;
  nqc_mode_e         cur_mode;

  nqc_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .addr      (bus_addr),
    .byte_mode (byte_mode),
    .cmd_hit   (cmd_hit),
    .tbl_off   (tbl_off),
    .tbl_valid (tbl_valid)
  );

  nqc_param_rom #(.DATA_W(DATA_W)) u_rom (
    .off   (tbl_off),
    .entry (rom_entry)
  );

  nqc_mode_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wdata      (bus_wdata),
    .cmd_hit    (cmd_hit),
    .auto_enter (auto_enter),
    .mode       (cur_mode)
  );

  always_comb begin
    if (!tbl_valid)     query_word = '0;
    else if (byte_mode) query_word = {{(DATA_W-HALF_W){1'b0}}, rom_entry[HALF_W-1:0]};
    else                query_word = rom_entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (cur_mode)
        MODE_ARRAY: rd_data <= array_rdata;
        MODE_QUERY: rd_data <= query_word;
        default:    rd_data <= '0;
      endcase
    end
  end

  assign mode = cur_mode;

  // R2: array reads pass the sampled array word through
  a_r2_array_pass: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cur_mode == MODE_ARRAY) |=> (rd_data == $past(array_rdata)));

  // R2: output holds between reads
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R8: query reads outside the table give zero
  a_r8_outside_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cur_mode == MODE_QUERY && !tbl_valid) |=> (rd_data == '0));

  // R9: autoselect reads give zero
  a_r9_auto_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cur_mode == MODE_AUTO) |=> (rd_data == '0));
endmodule

// File: tb/sim_nor_query_ctrl.sv
module sim_nor_query_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int NVEC = 24;

  // {byte_mode, address, expected data}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0, 12'h010, 16'h0051}, {1'b0, 12'h011, 16'h0052},
    {1'b0, 12'h012, 16'h0059}, {1'b0, 12'h013, 16'h0002},
    {1'b0, 12'h015, 16'h0040}, {1'b0, 12'h01B, 16'h0045},
    {1'b0, 12'h01C, 16'h0055}, {1'b0, 12'h01F, 16'h0004},
    {1'b0, 12'h021, 16'h000A}, {1'b0, 12'h023, 16'h0005},
    {1'b0, 12'h025, 16'h0004}, {1'b0, 12'h026, 16'h0000},
    {1'b0, 12'h00F, 16'h0000}, {1'b0, 12'h027, 16'h0000},
    {1'b0, 12'h090, 16'h0000}, {1'b0, 12'h110, 16'h0000},
    {1'b1, 12'h020, 16'h0051}, {1'b1, 12'h024, 16'h0059},
    {1'b1, 12'h036, 16'h0045}, {1'b1, 12'h038, 16'h0055},
    {1'b1, 12'h042, 16'h000A}, {1'b1, 12'h021, 16'h0000},
    {1'b1, 12'h04C, 16'h0000}, {1'b1, 12'h120, 16'h0000}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0]        bus_wdata = '0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic              byte_mode = 1'b0;
  logic              auto_enter = 1'b0;
  logic [DATA_W-1:0] array_rdata = 16'hA5C3;
  logic [DATA_W-1:0] rd_data;
  logic [1:0]        mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_query_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .wr_en(wr_en), .rd_en(rd_en), .byte_mode(byte_mode),
    .auto_enter(auto_enter), .array_rdata(array_rdata),
    .rd_data(rd_data), .mode(mode)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d, input logic bm);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; byte_mode = bm; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic bm, output logic [15:0] q);
    @(negedge clk);
    bus_addr = a; byte_mode = bm; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    q = rd_data;
  endtask

  task automatic pulse_auto();
    @(negedge clk);
    auto_enter = 1'b1;
    @(posedge clk);
    @(negedge clk);
    auto_enter = 1'b0;
  endtask

  initial begin
    logic [15:0] q;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 mode after reset", 16'(mode), 16'd0);
    check("R1 rd_data after reset", rd_data, 16'h0000);

    rd(12'h010, 1'b0, q);
    check("R2 array read", q, 16'hA5C3);
    @(negedge clk); array_rdata = 16'h1234;
    @(negedge clk);
    check("R2 hold without read", rd_data, 16'hA5C3);
    rd(12'h000, 1'b0, q);
    check("R2 second array read", q, 16'h1234);

    wr(12'h056, 8'h98, 1'b0);
    check("R4 wrong word address", 16'(mode), 16'd0);
    wr(12'h0AA, 8'h98, 1'b0);
    check("R4 byte address in word mode", 16'(mode), 16'd0);
    wr(12'h055, 8'h90, 1'b0);
    check("R4 other data ignored", 16'(mode), 16'd0);
    wr(12'h055, 8'h98, 1'b0);
    check("R4 query entry word mode", 16'(mode), 16'd2);

    for (int i = 0; i < NVEC; i++) begin
      rd(VEC[i][27:16], VEC[i][28], q);
      check(VEC[i][28] ? "R7 byte table vector" : "R6/R8 word table vector", q, VEC[i][15:0]);
    end
    check("R9 no array data in query", (rd_data == array_rdata) ? 16'd1 : 16'd0, 16'd0);

    wr(12'h123, 8'hF0, 1'b0);
    check("R5 query to array", 16'(mode), 16'd0);
    rd(12'h010, 1'b0, q);
    check("R5 array restored", q, 16'h1234);

    wr(12'h321, 8'hF0, 1'b0);
    check("R5 reset in array mode", 16'(mode), 16'd0);

    pulse_auto();
    check("R3 autoselect entry", 16'(mode), 16'd1);
    rd(12'h010, 1'b0, q);
    check("R9 autoselect read zero", q, 16'h0000);
    wr(12'h0AA, 8'h98, 1'b1);
    check("R4 query entry from autoselect byte mode", 16'(mode), 16'd2);
    rd(12'h022, 1'b1, q);
    check("R7 byte read 22h", q, 16'h0052);
    pulse_auto();
    check("R3 auto_enter ignored in query", 16'(mode), 16'd2);
    wr(12'h055, 8'h98, 1'b0);
    check("R5 repeated query keeps mode", 16'(mode), 16'd2);
    wr(12'h000, 8'hF0, 1'b1);
    check("R5 query back to autoselect", 16'(mode), 16'd1);
    pulse_auto();
    check("R3 auto_enter in autoselect", 16'(mode), 16'd1);
    wr(12'h000, 8'hF0, 1'b0);
    check("R5 autoselect to array", 16'(mode), 16'd0);

    @(negedge clk);
    auto_enter = 1'b1; wr_en = 1'b1; bus_wdata = 8'h00; bus_addr = 12'h001;
    @(posedge clk);
    @(negedge clk);
    auto_enter = 1'b0; wr_en = 1'b0;
    check("R3 auto_enter blocked by write", 16'(mode), 16'd0);

    wr(12'h055, 8'h98, 1'b0);
    rd(12'h01C, 1'b0, q);
    check("R6 supply max", q, 16'h0055);
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R1 reset from query mode", 16'(mode), 16'd0);
    check("R1 reset clears rd_data", rd_data, 16'h0000);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule